// File: doc/BRIEF.md
# Nibble-Prefixed Instruction Decoder Stack

This block takes a stream of one-byte instructions. The upper nibble of each byte is a function code and the lower nibble is a data nibble. Operands wider than four bits are assembled in an operand register across any number of prefix bytes. A positive prefix shifts the value built so far up by one nibble. A negative prefix complements it before the shift, which is how negative constants are formed. The operate code treats the assembled operand as a secondary opcode.

A three-entry evaluation stack (A on top, then B, then C) is held inside the block. Constant loads, constant adds, constant compares, swap, add, subtract, wrapping difference and signed greater-than all run locally. All other operations (memory access, branches, calls, channel and process operations) are not executed here. The block raises a decoded-operation tag and the operand value for an external unit, and holds both until that unit accepts them. Further input bytes are refused until the tag is accepted.

Top module: `nib_decoder`

## Requirements
- R1: After reset the operand register, A, B, C, the overflow flag and op_valid are all zero, and in_ready is 1.
- R2: For an accepted byte, let t = operand register OR the data nibble. Code 2 (positive prefix) loads the operand register with t shifted left by 4. Code 6 (negative prefix) loads it with the bitwise complement of t shifted left by 4. Every other code clears the operand register to zero.
- R3: Code 4 pushes t: A gets t, B gets the old A, C gets the old B, and the old C is dropped.
- R4: Code 8 replaces A with A + t, wrapping, with no flag. Code 12 replaces A with 1 if A equals t and with 0 otherwise. B and C are unchanged by both codes.
- R5: Code 15 with t = 0 swaps A and B and leaves C unchanged.
- R6: Code 15 with t = 5 (add), t = 12 (subtract, B − A) or t = 4 (difference, B − A) writes the result to A, copies C into B, and leaves C unchanged.
- R7: The overflow flag is set by a signed overflow of add (t = 5) or subtract (t = 12), and stays set until reset. The difference operation (t = 4) never sets it.
- R8: Code 15 with t = 9 writes 1 to A when B > A as two's-complement values and 0 otherwise, copies C into B, and leaves C unchanged.
- R9: Codes 0, 1, 3, 5, 7, 9, 10, 11, 13 and 14 leave the stack unchanged. They raise op_valid with op_fn equal to the code and op_operand equal to t.
- R10: Code 15 with any t other than 0, 4, 5, 9 or 12, including t of 16 or more, leaves the stack unchanged. It raises op_valid with op_fn = 15 and op_operand = t.
- R11: While op_valid is 1, in_ready is 0, input bytes are ignored, and the tag is held. op_valid falls on the clock edge where op_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte: function code in [7:4], data nibble in [3:0] |
| in_ready | output | 1 | Byte is taken on this edge when in_valid is also 1 |
| op_ready | input | 1 | External unit accepts the decoded-operation tag |
| oreg | output | W | Operand register |
| reg_a | output | W | Stack top |
| reg_b | output | W | Stack second entry |
| reg_c | output | W | Stack third entry |
| ovf_err | output | 1 | Sticky signed-overflow flag |
| op_valid | output | 1 | Decoded-operation tag pending |
| op_fn | output | 4 | Function code of the pending operation |
| op_operand | output | W | Operand of the pending operation |

## Verification
The bound checker verifies several properties on every cycle:
- the operand register is cleared after each non-prefix byte;
- the push shifts the stack entries down;
- the compare result is a single bit;
- the overflow flag stays set once raised;
- the pending tag and the stack stay frozen while the external unit stalls;
- the tag carries the primary code that raised it.

The bench's scenarios are needed for the arithmetic values themselves. These cover:
- operands built from long prefix chains that include negative prefixes;
- signed overflow at the positive limit;
- difference wrapping without setting the flag;
- signed comparison across zero;
- secondary opcodes of 16 or more being sent out instead of executed.

// File: rtl/nib_decoder.sv
module nib_decoder #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_byte,
  output logic         in_ready,
  input  logic         op_ready,
  output logic [W-1:0] oreg,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic [W-1:0] reg_c,
  output logic         ovf_err,
  output logic         op_valid,
  output logic [3:0]   op_fn,
  output logic [W-1:0] op_operand
);
  localparam logic [3:0] F_PFIX = 4'd2, F_LDC = 4'd4, F_NFIX = 4'd6,
                         F_ADC  = 4'd8, F_EQC = 4'd12, F_OPR  = 4'd15;
  localparam logic [W-1:0] S_REV = W'(0), S_DIFF = W'(4), S_ADD = W'(5),
                           S_GT  = W'(9), S_SUB  = W'(12);

  logic [3:0]   fn;
  logic [W-1:0] opnd, sum, dif;
  logic         take, add_ovf, sub_ovf, gt, local_sec, external;

  assign fn       = in_byte[7:4];
  assign in_ready = !op_valid;
  assign take     = in_valid && in_ready;
  assign opnd     = oreg | {{(W-4){1'b0}}, in_byte[3:0]};
  assign sum      = reg_b + reg_a;
  assign dif      = reg_b - reg_a;
  assign add_ovf  = (reg_b[W-1] == reg_a[W-1]) && (sum[W-1] != reg_b[W-1]);
  assign sub_ovf  = (reg_b[W-1] != reg_a[W-1]) && (dif[W-1] != reg_b[W-1]);
  assign gt       = $signed(reg_b) > $signed(reg_a);
  assign local_sec = (fn == F_OPR) &&
                     (opnd == S_REV || opnd == S_DIFF || opnd == S_ADD ||
                      opnd == S_GT  || opnd == S_SUB);
  assign external = !(fn == F_PFIX || fn == F_NFIX || fn == F_LDC ||
                      fn == F_ADC  || fn == F_EQC  || local_sec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oreg       <= '0;
      reg_a      <= '0;
      reg_b      <= '0;
      reg_c      <= '0;
      ovf_err    <= 1'b0;
      op_valid   <= 1'b0;
      op_fn      <= '0;
      op_operand <= '0;
    end else begin
      if (op_valid && op_ready) op_valid <= 1'b0;
      if (take) begin
        if (fn == F_PFIX)      oreg <= opnd << 4;
        else if (fn == F_NFIX) oreg <= (~opnd) << 4;
        else                   oreg <= '0;
        case (fn)
          F_LDC: begin
            reg_a <= opnd;
            reg_b <= reg_a;
            reg_c <= reg_b;
          end
          F_ADC: reg_a <= reg_a + opnd;
          F_EQC: reg_a <= {{(W-1){1'b0}}, reg_a == opnd};
          F_OPR: if (local_sec) begin
            if (opnd == S_REV) begin
              reg_a <= reg_b;
              reg_b <= reg_a;
            end else begin
              reg_b <= reg_c;
              if (opnd == S_ADD) begin
                reg_a <= sum;
                if (add_ovf) ovf_err <= 1'b1;
              end else if (opnd == S_SUB) begin
                reg_a <= dif;
                if (sub_ovf) ovf_err <= 1'b1;
              end else if (opnd == S_DIFF) begin
                reg_a <= dif;
              end else begin
                reg_a <= {{(W-1){1'b0}}, gt};
              end
            end
          end
          default: ;
        endcase
        if (external) begin
          op_valid   <= 1'b1;
          op_fn      <= fn;
          op_operand <= opnd;
        end
      end
    end
  end
endmodule

// File: rtl/nib_decoder_sva.sv
module nib_decoder_sva #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [7:0]   in_byte,
  input logic         in_ready,
  input logic         op_ready,
  input logic [W-1:0] oreg,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [W-1:0] reg_c,
  input logic         ovf_err,
  input logic         op_valid,
  input logic [3:0]   op_fn,
  input logic [W-1:0] op_operand
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_byte[7:4] != 4'd2 && in_byte[7:4] != 4'd6 |=> oreg == '0);

  p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_byte[7:4] == 4'd4 |=> reg_b == $past(reg_a) && reg_c == $past(reg_b));

  p_bool_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_byte[7:4] == 4'd12 |=> reg_a[W-1:1] == '0);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_byte[7:4] == 4'd7 || in_byte[7:4] == 4'd13 || in_byte[7:4] == 4'd0)
    |=> op_valid && op_fn == $past(in_byte[7:4]));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_fn) && $stable(op_operand));

  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> $stable(reg_a) && $stable(reg_b) && $stable(reg_c) && $stable(oreg));
endmodule

bind nib_decoder nib_decoder_sva #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .in_ready(in_ready), .op_ready(op_ready), .oreg(oreg), .reg_a(reg_a),
  .reg_b(reg_b), .reg_c(reg_c), .ovf_err(ovf_err), .op_valid(op_valid),
  .op_fn(op_fn), .op_operand(op_operand)
);

// File: tb/nib_decoder_tb.sv
module nib_decoder_tb_top;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, op_ready = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, ovf_err, op_valid;
  logic [3:0] op_fn;
  logic [W-1:0] oreg, reg_a, reg_b, reg_c, op_operand;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_o, m_a, m_b, m_c, m_opd;
  logic m_e, m_v;
  logic [3:0] m_fn;
  string m_tag;

  always #10 clk = ~clk;

  nib_decoder #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .op_ready(op_ready), .oreg(oreg), .reg_a(reg_a),
    .reg_b(reg_b), .reg_c(reg_c), .ovf_err(ovf_err), .op_valid(op_valid),
    .op_fn(op_fn), .op_operand(op_operand)
  );

  function automatic logic is_ovf_add(logic [W-1:0] b, logic [W-1:0] a);
    logic [W-1:0] s = b + a;
    return (b[W-1] == a[W-1]) && (s[W-1] != b[W-1]);
  endfunction

  function automatic logic is_ovf_sub(logic [W-1:0] b, logic [W-1:0] a);
    logic [W-1:0] s = b - a;
    return (b[W-1] != a[W-1]) && (s[W-1] != b[W-1]);
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(bit v, logic [7:0] b, bit rdy);
    logic [W-1:0] t;
    logic [3:0] f;
    bit acc = v && !m_v;
    m_tag = "R11";
    if (m_v && rdy) m_v = 0;
    if (!acc) return;
    f = b[7:4];
    t = m_o | W'(b[3:0]);
    m_o = (f == 2) ? t << 4 : (f == 6) ? (~t) << 4 : '0;
    case (f)
      2, 6: m_tag = "R2";
      4: begin m_c = m_b; m_b = m_a; m_a = t; m_tag = "R3"; end
      8: begin m_a = m_a + t; m_tag = "R4"; end
      12: begin m_a = W'(m_a == t); m_tag = "R4"; end
      15: begin
        if (t == 0) begin
          {m_a, m_b} = {m_b, m_a}; m_tag = "R5";
        end else if (t == 4) begin
          m_a = m_b - m_a; m_b = m_c; m_tag = "R6/R7";
        end else if (t == 5) begin
          if (is_ovf_add(m_b, m_a)) m_e = 1;
          m_a = m_b + m_a; m_b = m_c; m_tag = "R6/R7";
        end else if (t == 12) begin
          if (is_ovf_sub(m_b, m_a)) m_e = 1;
          m_a = m_b - m_a; m_b = m_c; m_tag = "R6/R7";
        end else if (t == 9) begin
          m_a = W'($signed(m_b) > $signed(m_a)); m_b = m_c; m_tag = "R8";
        end else begin
          m_v = 1; m_fn = 15; m_opd = t; m_tag = "R10";
        end
      end
      default: begin m_v = 1; m_fn = f; m_opd = t; m_tag = "R9"; end
    endcase
  endtask

  task automatic compare();
    chk(m_tag, "oreg", oreg, m_o);
    chk(m_tag, "A", reg_a, m_a);
    chk(m_tag, "B", reg_b, m_b);
    chk(m_tag, "C", reg_c, m_c);
    chk(m_tag, "ovf", W'(ovf_err), W'(m_e));
    chk(m_tag, "op_valid", W'(op_valid), W'(m_v));
    chk("R11", "in_ready", W'(in_ready), W'(!m_v));
    if (m_v) begin
      chk(m_tag, "op_fn", W'(op_fn), W'(m_fn));
      chk(m_tag, "op_operand", op_operand, m_opd);
    end
  endtask

  task automatic step(bit v, logic [7:0] b, bit rdy);
    in_valid = v; in_byte = b; op_ready = rdy;
    @(posedge clk);
    model(v, b, rdy);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; op_ready = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_o = '0; m_a = '0; m_b = '0; m_c = '0; m_e = 0; m_v = 0; m_fn = '0; m_opd = '0;
    m_tag = "R1";
    compare();
  endtask

  task automatic push_max();
    step(1, 8'h27, 1);
    for (int i = 0; i < 6; i++) step(1, 8'h2F, 1);
    step(1, 8'h4F, 1);
  endtask

  initial begin
    void'($urandom(32'h1D5EED));
    @(negedge clk);
    do_reset();
    chk("R1", "reset A", reg_a, '0);

    step(1, 8'h21, 1); step(1, 8'h22, 1); step(1, 8'h43, 1);
    chk("R2", "prefix chain", reg_a, 32'h123);
    step(1, 8'h60, 1); step(1, 8'h4F, 1);
    chk("R2", "negative prefix", reg_a, 32'hFFFF_FFFF);
    step(1, 8'hC1, 1);
    chk("R4", "eqc false", reg_a, 32'h0);

    do_reset();
    push_max(); step(1, 8'h41, 1); step(1, 8'hF5, 1);
    chk("R6", "add wrap", reg_a, 32'h8000_0000);
    chk("R7", "add overflow", W'(ovf_err), 1);

    do_reset();
    push_max(); step(1, 8'h60, 1); step(1, 8'h4F, 1); step(1, 8'hF4, 1);
    chk("R7", "diff result", reg_a, 32'h8000_0000);
    chk("R7", "diff no flag", W'(ovf_err), 0);

    do_reset();
    step(1, 8'h41, 1); step(1, 8'h60, 1); step(1, 8'h4F, 1); step(1, 8'hF9, 1);
    chk("R8", "gt signed", reg_a, 32'h1);

    step(1, 8'h21, 0); step(1, 8'hF1, 0);
    chk("R10", "sec external fn", W'(op_fn), 15);
    chk("R10", "sec external operand", op_operand, 32'h11);
    for (int i = 0; i < 4; i++) step(1, 8'h45, 0);
    chk("R11", "stalled stack", reg_a, 32'h1);
    step(0, 8'h00, 1);
    chk("R11", "tag released", W'(op_valid), 0);
    step(1, 8'h73, 1);
    chk("R9", "primary tag", W'(op_fn), 7);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      logic [3:0] nb = 4'($urandom);
      logic [3:0] fsel;
      logic [3:0] secs [5] = '{4'd0, 4'd4, 4'd5, 4'd9, 4'd12};
      logic [3:0] ext [10] = '{4'd0, 4'd1, 4'd3, 4'd5, 4'd7, 4'd9, 4'd10, 4'd11, 4'd13, 4'd14};
      if (r < 4) fsel = 4;
      else if (r < 6) fsel = 8;
      else if (r < 7) fsel = 12;
      else if (r < 9) fsel = 2;
      else if (r < 10) fsel = 6;
      else if (r < 14) begin fsel = 15; nb = secs[$urandom % 5]; end
      else if (r < 15) fsel = 15;
      else fsel = ext[$urandom % 10];
      if (i % 500 == 499) do_reset();
      step(($urandom % 8) != 0, {fsel, nb}, ($urandom % 4) != 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule